// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction parcel into the equivalent 32-bit base-encoding instruction word for a 64-bit integer core. It is purely combinational. A fetch or decode stage places an aligned parcel on its input and reads back, in the same cycle, either a full-width instruction or an illegal-instruction indication. The word is then decoded by the ordinary 32-bit decoder.

The parcel's two low bits pick one of three quadrants, and the three high bits pick the operation inside that quadrant. Every immediate that the compressed formats scatter across the parcel is put back together, scaled and extended as the operation requires. The operand combinations that the compressed encoding reserves raise the illegal flag. When the flag is set the output word is forced to zero. Compressed floating-point loads and stores are not supported and come out as illegal. A parcel with low bits `11` is not a compressed parcel: the block only reports it as illegal, and fetch must not send it here.

Top module: `cparcel_expander`

## Requirements
- R1: Bits [1:0] of the parcel select the quadrant (00, 01, 10) and bits [15:13] select the operation. The all-zero parcel is illegal, and any parcel with bits [1:0] = 11 is illegal.
- R2: When illegal_o is 1, word_o is 32'h0. When illegal_o is 0, word_o[1:0] is 11.
- R3: Quadrant 0, op 000 expands to an add-immediate with rd = 8+parcel[4:2], rs1 = x2 and an unsigned immediate that is a multiple of 4 (bits 9:2 rebuilt from the parcel). A zero immediate is illegal.
- R4: Quadrant 0 word loads and stores (op 010, 110) use an offset that is a multiple of 4 up to 124. Doubleword forms (op 011, 111) use parcel[12:10] shifted left by 3, ORed with parcel[6:5] shifted left by 6. Registers are 8+parcel[9:7] (base) and 8+parcel[4:2] (data).
- R5: Quadrant 2 stack-relative loads (op 010, 011) and stores (op 110, 111) use base x2 and zero-extended offsets: multiples of 4 up to 252 for word forms and multiples of 8 up to 504 for doubleword forms. A load with rd = x0 is illegal.
- R6: Quadrant 1 op 000 adds a sign-extended 6-bit immediate to rd. It is illegal when exactly one of "rd is x0" and "immediate is zero" holds, and the case where both hold is a legal no-op. Op 001 (32-bit add) and op 010 (load immediate) are illegal with rd = x0.
- R7: Quadrant 1 op 011 with rd = x2 adjusts x2 by a sign-extended multiple of 16 and is illegal when that value is zero. With any other rd it loads an upper immediate sign-extended from bit 17, and it is illegal when rd is x0 or the immediate is zero.
- R8: Logical and arithmetic right shifts (quadrant 1) and the left shift (quadrant 2) take a 6-bit amount {parcel[12], parcel[6:2]}. An amount of zero is illegal. The and-immediate form sign-extends its 6-bit immediate.
- R9: The quadrant 1 register ALU group yields subtract, xor, or, and, 32-bit subtract and 32-bit add, selected by {parcel[12], parcel[6:5]} = 000..101. The codes 110 and 111 are illegal.
- R10: Quadrant 1 op 101 yields a jump with rd = x0. Its offset has bit 0 at zero and is sign-extended from bit 11.
- R11: Quadrant 1 op 110 and op 111 yield branch-if-zero and branch-if-nonzero against x0. The 9-bit even offset is sign-extended.
- R12: Quadrant 2 op 100: a register jump or jump-and-link with rs1 = x0 is illegal. The link form with both register fields x0 is a breakpoint (32'h00100073). A move with rd = x0 is illegal. Otherwise the form expands to move or add.
- R13: The compressed floating-point slots (quadrant 0 ops 001 and 101, quadrant 2 ops 001 and 101) and the reserved quadrant 0 op 100 are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| parcel_i | input | 16 | Compressed instruction parcel |
| word_o | output | 32 | Expanded base instruction, zero when illegal |
| illegal_o | output | 1 | Parcel is reserved, unsupported or not compressed |

## Verification
The checker continuously enforces the relations between the parcel and the outputs that do not depend on the details of the immediates: all-zero and non-compressed parcels flag illegal, unsupported slots flag illegal, a zero shift amount is rejected, legal output always carries a 32-bit opcode, and the breakpoint and stack-add forms keep their fixed fields. Whether each scattered immediate lands in the right bit of the rebuilt instruction, and whether the sign extension and scaling are right, can only be shown by the bench. Its sweeps build each parcel from a chosen offset or immediate and compare the result with the base encoding computed from that same value. A full sweep of all 65,536 parcels then confirms the illegal/zero relation and the unsupported slots.

// File: rtl/cx_pkg.sv
// Shared widths, base opcodes and base-format word builders for the
// compressed parcel expander. Assumes a 64-bit integer base encoding.
package cx_pkg;
    localparam int PARCEL_W = 16;
    localparam int WORD_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int F3_W     = 3;
    localparam int OPC_W    = 7;
    localparam int QUADS    = 4;

    typedef logic [PARCEL_W-1:0] parcel_t;
    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [RIDX_W-1:0]   ridx_t;
    typedef logic [F3_W-1:0]     f3_t;
    typedef logic [OPC_W-1:0]    opc_t;

    typedef struct packed {
        logic  bad;
        word_t word;
    } xlat_t;

    localparam opc_t OPC_LOAD   = 7'b0000011;
    localparam opc_t OPC_STORE  = 7'b0100011;
    localparam opc_t OPC_OPIMM  = 7'b0010011;
    localparam opc_t OPC_OPIMMW = 7'b0011011;
    localparam opc_t OPC_OP     = 7'b0110011;
    localparam opc_t OPC_OPW    = 7'b0111011;
    localparam opc_t OPC_LUI    = 7'b0110111;
    localparam opc_t OPC_BRANCH = 7'b1100011;
    localparam opc_t OPC_JALR   = 7'b1100111;
    localparam opc_t OPC_JAL    = 7'b1101111;
    localparam opc_t OPC_SYSTEM = 7'b1110011;

    localparam ridx_t REG_ZERO = 5'd0;
    localparam ridx_t REG_LINK = 5'd1;
    localparam ridx_t REG_SP   = 5'd2;

    // Immediate-format word
    function automatic word_t mk_i(input logic [11:0] imm, input ridx_t rs1,
                                   input f3_t f3, input ridx_t rd, input opc_t opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    // Register-register word
    function automatic word_t mk_r(input logic [6:0] f7, input ridx_t rs2, input ridx_t rs1,
                                   input f3_t f3, input ridx_t rd, input opc_t opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    // Store word
    function automatic word_t mk_s(input logic [11:0] imm, input ridx_t rs2, input ridx_t rs1,
                                   input f3_t f3, input opc_t opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    // Branch word; imm bit 0 is implicit
    function automatic word_t mk_b(input logic [12:0] imm, input ridx_t rs2, input ridx_t rs1,
                                   input f3_t f3, input opc_t opc);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], opc};
    endfunction

    // Upper-immediate word
    function automatic word_t mk_u(input logic [19:0] imm, input ridx_t rd, input opc_t opc);
        return {imm, rd, opc};
    endfunction

    // Jump word; imm bit 0 is implicit
    function automatic word_t mk_j(input logic [20:0] imm, input ridx_t rd, input opc_t opc);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, opc};
    endfunction

    // 3-bit short register field maps onto x8..x15
    function automatic ridx_t short_reg(input logic [2:0] r);
        return {2'b01, r};
    endfunction
endpackage

// File: rtl/cx_q0_dec.sv
// Quadrant 0 decoder: stack-scaled add, word/doubleword loads and stores.
// Assumes parcel[1:0] == 00; the top selects its result only in that case.
module cx_q0_dec
    import cx_pkg::*;
(
    input  parcel_t c,
    output xlat_t   res
);
    logic [9:0] spadd_imm;
    logic [6:0] w_off;
    logic [7:0] d_off;
    ridx_t      rs_base;
    ridx_t      rs_data;

    // Rebuild the scattered offsets and short registers
    always_comb begin
        spadd_imm = {c[10:7], c[12:11], c[5], c[6], 2'b00};
        w_off     = {c[5], c[12:10], c[6], 2'b00};
        d_off     = {c[6:5], c[12:10], 3'b000};
        rs_base   = short_reg(c[9:7]);
        rs_data   = short_reg(c[4:2]);
    end

    // Select the operation by the top three bits
    always_comb begin
        res = '{bad: 1'b1, word: '0};
        case (c[15:13])
            3'b000: begin
                res.word = mk_i({2'b00, spadd_imm}, REG_SP, 3'b000, rs_data, OPC_OPIMM);
                res.bad  = (spadd_imm == '0);
            end
            3'b010: res = '{bad: 1'b0, word: mk_i({5'b0, w_off}, rs_base, 3'b010, rs_data, OPC_LOAD)};
            3'b011: res = '{bad: 1'b0, word: mk_i({4'b0, d_off}, rs_base, 3'b011, rs_data, OPC_LOAD)};
            3'b110: res = '{bad: 1'b0, word: mk_s({5'b0, w_off}, rs_data, rs_base, 3'b010, OPC_STORE)};
            3'b111: res = '{bad: 1'b0, word: mk_s({4'b0, d_off}, rs_data, rs_base, 3'b011, OPC_STORE)};
            default: res = '{bad: 1'b1, word: '0};
        endcase
    end
endmodule

// File: rtl/cx_q1_dec.sv
// Quadrant 1 decoder: immediates, upper immediate, stack adjust, shifts,
// register ALU group, jump and zero-compare branches.
// Assumes parcel[1:0] == 01; the top selects its result only in that case.
module cx_q1_dec
    import cx_pkg::*;
(
    input  parcel_t c,
    output xlat_t   res
);
    logic [5:0]  imm6;
    logic [11:0] simm12;
    logic [9:0]  sp_adj;
    logic [11:0] j_off;
    logic [8:0]  b_off;
    ridx_t       rd;
    ridx_t       rp1;
    ridx_t       rp2;

    // Rebuild immediates and register fields
    always_comb begin
        imm6   = {c[12], c[6:2]};
        simm12 = {{6{imm6[5]}}, imm6};
        sp_adj = {c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
        j_off  = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
        b_off  = {c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
        rd     = c[11:7];
        rp1    = short_reg(c[9:7]);
        rp2    = short_reg(c[4:2]);
    end

    // Select the operation and apply the reserved-operand rules
    always_comb begin
        res = '{bad: 1'b1, word: '0};
        case (c[15:13])
            3'b000: begin
                res.word = mk_i(simm12, rd, 3'b000, rd, OPC_OPIMM);
                res.bad  = (rd == REG_ZERO) != (imm6 == '0);
            end
            3'b001: begin
                res.word = mk_i(simm12, rd, 3'b000, rd, OPC_OPIMMW);
                res.bad  = (rd == REG_ZERO);
            end
            3'b010: begin
                res.word = mk_i(simm12, REG_ZERO, 3'b000, rd, OPC_OPIMM);
                res.bad  = (rd == REG_ZERO);
            end
            3'b011: begin
                if (rd == REG_SP) begin
                    res.word = mk_i({{2{sp_adj[9]}}, sp_adj}, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
                    res.bad  = (sp_adj == '0);
                end else begin
                    res.word = mk_u({{14{imm6[5]}}, imm6}, rd, OPC_LUI);
                    res.bad  = (rd == REG_ZERO) || (imm6 == '0);
                end
            end
            3'b100: begin
                case (c[11:10])
                    2'b00: begin
                        res.word = mk_i({6'b000000, imm6}, rp1, 3'b101, rp1, OPC_OPIMM);
                        res.bad  = (imm6 == '0);
                    end
                    2'b01: begin
                        res.word = mk_i({6'b010000, imm6}, rp1, 3'b101, rp1, OPC_OPIMM);
                        res.bad  = (imm6 == '0);
                    end
                    2'b10: res = '{bad: 1'b0, word: mk_i(simm12, rp1, 3'b111, rp1, OPC_OPIMM)};
                    default: begin
                        case ({c[12], c[6:5]})
                            3'b000: res = '{bad: 1'b0, word: mk_r(7'b0100000, rp2, rp1, 3'b000, rp1, OPC_OP)};
                            3'b001: res = '{bad: 1'b0, word: mk_r(7'b0000000, rp2, rp1, 3'b100, rp1, OPC_OP)};
                            3'b010: res = '{bad: 1'b0, word: mk_r(7'b0000000, rp2, rp1, 3'b110, rp1, OPC_OP)};
                            3'b011: res = '{bad: 1'b0, word: mk_r(7'b0000000, rp2, rp1, 3'b111, rp1, OPC_OP)};
                            3'b100: res = '{bad: 1'b0, word: mk_r(7'b0100000, rp2, rp1, 3'b000, rp1, OPC_OPW)};
                            3'b101: res = '{bad: 1'b0, word: mk_r(7'b0000000, rp2, rp1, 3'b000, rp1, OPC_OPW)};
                            default: res = '{bad: 1'b1, word: '0};
                        endcase
                    end
                endcase
            end
            3'b101: res = '{bad: 1'b0, word: mk_j({{9{j_off[11]}}, j_off}, REG_ZERO, OPC_JAL)};
            3'b110: res = '{bad: 1'b0, word: mk_b({{4{b_off[8]}}, b_off}, REG_ZERO, rp1, 3'b000, OPC_BRANCH)};
            default: res = '{bad: 1'b0, word: mk_b({{4{b_off[8]}}, b_off}, REG_ZERO, rp1, 3'b001, OPC_BRANCH)};
        endcase
    end
endmodule

// File: rtl/cx_q2_dec.sv
// Quadrant 2 decoder: left shift, stack-relative loads and stores, register
// jumps, move, add and breakpoint. Assumes parcel[1:0] == 10.
module cx_q2_dec
    import cx_pkg::*;
(
    input  parcel_t c,
    output xlat_t   res
);
    logic [5:0] imm6;
    logic [7:0] lw_off;
    logic [8:0] ld_off;
    logic [7:0] sw_off;
    logic [8:0] sd_off;
    ridx_t      rd;
    ridx_t      rs2;

    // Rebuild stack offsets and register fields
    always_comb begin
        imm6   = {c[12], c[6:2]};
        lw_off = {c[3:2], c[12], c[6:4], 2'b00};
        ld_off = {c[4:2], c[12], c[6:5], 3'b000};
        sw_off = {c[8:7], c[12:9], 2'b00};
        sd_off = {c[9:7], c[12:10], 3'b000};
        rd     = c[11:7];
        rs2    = c[6:2];
    end

    // Select the operation and apply the reserved-operand rules
    always_comb begin
        res = '{bad: 1'b1, word: '0};
        case (c[15:13])
            3'b000: begin
                res.word = mk_i({6'b000000, imm6}, rd, 3'b001, rd, OPC_OPIMM);
                res.bad  = (imm6 == '0);
            end
            3'b010: begin
                res.word = mk_i({4'b0, lw_off}, REG_SP, 3'b010, rd, OPC_LOAD);
                res.bad  = (rd == REG_ZERO);
            end
            3'b011: begin
                res.word = mk_i({3'b0, ld_off}, REG_SP, 3'b011, rd, OPC_LOAD);
                res.bad  = (rd == REG_ZERO);
            end
            3'b100: begin
                if (!c[12]) begin
                    if (rs2 == REG_ZERO)
                        res.word = mk_i(12'd0, rd, 3'b000, REG_ZERO, OPC_JALR);
                    else
                        res.word = mk_r(7'd0, rs2, REG_ZERO, 3'b000, rd, OPC_OP);
                    res.bad = (rd == REG_ZERO);
                end else if (rs2 == REG_ZERO) begin
                    if (rd == REG_ZERO)
                        res.word = mk_i(12'd1, REG_ZERO, 3'b000, REG_ZERO, OPC_SYSTEM);
                    else
                        res.word = mk_i(12'd0, rd, 3'b000, REG_LINK, OPC_JALR);
                    res.bad = 1'b0;
                end else begin
                    res = '{bad: 1'b0, word: mk_r(7'd0, rs2, rd, 3'b000, rd, OPC_OP)};
                end
            end
            3'b110: res = '{bad: 1'b0, word: mk_s({4'b0, sw_off}, rs2, REG_SP, 3'b010, OPC_STORE)};
            3'b111: res = '{bad: 1'b0, word: mk_s({3'b0, sd_off}, rs2, REG_SP, 3'b011, OPC_STORE)};
            default: res = '{bad: 1'b1, word: '0};
        endcase
    end
endmodule

// File: rtl/cparcel_expander.sv
// Compressed parcel expander top: runs the three quadrant decoders in
// parallel, picks one by parcel[1:0] and zeroes the word when illegal.
// Purely combinational; assumes the parcel is already aligned.
module cparcel_expander
    import cx_pkg::*;
(
    input  logic [15:0] parcel_i,
    output logic [31:0] word_o,
    output logic        illegal_o
);
    xlat_t lane [QUADS];
    xlat_t pick;

    cx_q0_dec q0_i (.c(parcel_i), .res(lane[0]));
    cx_q1_dec q1_i (.c(parcel_i), .res(lane[1]));
    cx_q2_dec q2_i (.c(parcel_i), .res(lane[2]));

    // Low bits 11 mark a full-width instruction: never expandable here
    assign lane[QUADS-1] = '{bad: 1'b1, word: '0};

    // Quadrant selection and illegal masking
    always_comb begin
        pick      = lane[parcel_i[1:0]];
        illegal_o = pick.bad;
        word_o    = pick.bad ? '0 : pick.word;
    end
endmodule

// File: rtl/cparcel_expander_chk.sv
// Property checker for the expander, bound into every instance.
module cparcel_expander_chk (
    input logic [15:0] parcel_i,
    input logic [31:0] word_o,
    input logic        illegal_o
);
    logic [2:0] op;
    logic [1:0] quad;
    assign op   = parcel_i[15:13];
    assign quad = parcel_i[1:0];

    // Input/output relations checked whenever the parcel settles
    always_comb begin
        assert_zero_parcel_R1: assert (parcel_i != 16'h0 || illegal_o)
            else $error("all-zero parcel accepted");
        assert_full_width_R1: assert (quad != 2'b11 || illegal_o)
            else $error("non-compressed parcel accepted");
        assert_opcode_tail_R2: assert (illegal_o || word_o[1:0] == 2'b11)
            else $error("legal word lacks base opcode tail");
        assert_illegal_zero_R2: assert (!illegal_o || word_o == 32'h0)
            else $error("illegal parcel leaked a word");
        assert_spadd_fields_R3: assert (illegal_o || quad != 2'b00 || op != 3'b000
                                        || (word_o[19:15] == 5'd2 && word_o[31:20] != 12'd0))
            else $error("stack add lost base or immediate");
        assert_zero_shift_R8: assert (!(((quad == 2'b01 && op == 3'b100 && parcel_i[11] == 1'b0)
                                        || (quad == 2'b10 && op == 3'b000))
                                       && parcel_i[12] == 1'b0 && parcel_i[6:2] == 5'd0) || illegal_o)
            else $error("zero shift amount accepted");
        assert_jump_link_R10: assert (illegal_o || quad != 2'b01 || op != 3'b101
                                      || (word_o[6:0] == 7'b1101111 && word_o[11:7] == 5'd0))
            else $error("jump form malformed");
        assert_breakpoint_R12: assert (parcel_i != 16'h9002 || (!illegal_o && word_o == 32'h00100073))
            else $error("breakpoint form malformed");
        assert_fp_slots_R13: assert (!(((quad == 2'b00) && (op == 3'b001 || op == 3'b100 || op == 3'b101))
                                       || ((quad == 2'b10) && (op == 3'b001 || op == 3'b101))) || illegal_o)
            else $error("unsupported slot accepted");
    end
endmodule

bind cparcel_expander cparcel_expander_chk chk_i (
    .parcel_i (parcel_i),
    .word_o   (word_o),
    .illegal_o(illegal_o)
);

// File: tb/cparcel_expander_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: builds parcels from chosen values, compares against
// base encodings built from the same values, then sweeps every parcel.
module cparcel_expander_tb_top;
    logic        clk = 1'b0;
    logic [15:0] parcel = 16'h0;
    logic [31:0] word;
    logic        ill;
    int          n_vec = 0;
    int          n_bad = 0;
    int          cyc   = 0;

    always #2.5 clk = ~clk;

    cparcel_expander dut_i (.parcel_i(parcel), .word_o(word), .illegal_o(ill));

    // Base-format builders
    function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] s1, logic [2:0] f3, logic [4:0] d, logic [6:0] op);
        return {im, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3, logic [4:0] d, logic [6:0] op);
        return {f7, s2, s1, f3, d, op};
    endfunction
    function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3);
        return {im[11:5], s2, s1, f3, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_b(logic [12:0] im, logic [4:0] s1, logic [2:0] f3);
        return {im[12], im[10:5], 5'd0, s1, f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] e_j(logic [20:0] im);
        return {im[20], im[10:1], im[11], im[19:12], 5'd0, 7'b1101111};
    endfunction

    // Compressed-format scatterers (field layout per requirement)
    function automatic logic [15:0] p_spadd(logic [9:0] im, logic [2:0] rp);
        return {3'b000, im[5:4], im[9:6], im[2], im[3], rp, 2'b00};
    endfunction
    function automatic logic [15:0] p_mw(logic [2:0] f3, logic [6:0] im, logic [2:0] b, logic [2:0] dr);
        return {f3, im[5:3], b, im[2], im[6], dr, 2'b00};
    endfunction
    function automatic logic [15:0] p_md(logic [2:0] f3, logic [7:0] im, logic [2:0] b, logic [2:0] dr);
        return {f3, im[5:3], b, im[7:6], dr, 2'b00};
    endfunction
    function automatic logic [15:0] p_ci(logic [2:0] f3, logic [5:0] im, logic [4:0] rd, logic [1:0] q);
        return {f3, im[5], rd, im[4:0], q};
    endfunction
    function automatic logic [15:0] p_a16(logic [9:0] im);
        return {3'b011, im[9], 5'd2, im[4], im[6], im[8:7], im[5], 2'b01};
    endfunction
    function automatic logic [15:0] p_cb(logic [1:0] f2, logic [5:0] im, logic [2:0] rp);
        return {3'b100, im[5], f2, rp, im[4:0], 2'b01};
    endfunction
    function automatic logic [15:0] p_alu(logic [2:0] sel, logic [2:0] rp1, logic [2:0] rp2);
        return {3'b100, sel[2], 2'b11, rp1, sel[1:0], rp2, 2'b01};
    endfunction
    function automatic logic [15:0] p_j(logic [11:0] o);
        return {3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
    endfunction
    function automatic logic [15:0] p_br(logic [2:0] f3, logic [8:0] o, logic [2:0] rp);
        return {f3, o[8], o[4:3], rp, o[7:6], o[2:1], o[5], 2'b01};
    endfunction
    function automatic logic [15:0] p_lwsp(logic [4:0] rd, logic [7:0] im);
        return {3'b010, im[5], rd, im[4:2], im[7:6], 2'b10};
    endfunction
    function automatic logic [15:0] p_ldsp(logic [4:0] rd, logic [8:0] im);
        return {3'b011, im[5], rd, im[4:3], im[8:6], 2'b10};
    endfunction
    function automatic logic [15:0] p_swsp(logic [4:0] rs, logic [7:0] im);
        return {3'b110, im[5:2], im[7:6], rs, 2'b10};
    endfunction
    function automatic logic [15:0] p_sdsp(logic [4:0] rs, logic [8:0] im);
        return {3'b111, im[5:3], im[8:6], rs, 2'b10};
    endfunction
    function automatic logic [15:0] p_cr(logic b12, logic [4:0] rd, logic [4:0] rs);
        return {3'b100, b12, rd, rs, 2'b10};
    endfunction

    // Apply one parcel and compare word and flag
    task automatic chk(input logic [15:0] p, input logic [31:0] ew, input logic eb, input string tag);
        @(negedge clk);
        parcel = p;
        #1;
        n_vec++;
        if (word !== ew || ill !== eb) begin
            n_bad++;
            $display("FAIL %s parcel=%h got word=%h ill=%b exp word=%h ill=%b", tag, p, word, ill, ew, eb);
        end
    endtask

    // Expect a legal word or, when bad, the illegal flag with a zero word
    task automatic chk_x(input logic [15:0] p, input logic [31:0] ew, input logic eb, input string tag);
        chk(p, eb ? 32'h0 : ew, eb, tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_bad++;
            $display("FAIL watchdog expired got cycle=%0d exp below=%0d", cyc, 190000);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: all-zero parcel (idle state) is illegal
        chk(16'h0000, 32'h0, 1'b1, "R1 zero parcel");
        // Hand-assembled anchors
        chk(16'h0001, 32'h00000013, 1'b0, "R6 nop");
        chk(16'h9002, 32'h00100073, 1'b0, "R12 breakpoint");
        chk(16'h8082, 32'h00008067, 1'b0, "R12 return jump");
        chk(16'h0003, 32'h0, 1'b1, "R1 full-width parcel");

        // R3: stack-scaled add
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < 256; u++)
                chk_x(p_spadd(10'(u * 4), 3'(r)),
                      e_i(12'(u * 4), 5'd2, 3'd0, {2'b01, 3'(r)}, 7'h13), u == 0, "R3 stack add");

        // R4: quadrant 0 word and doubleword memory
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < 32; u++) begin
                chk(p_mw(3'b010, 7'(u * 4), 3'(r), 3'(7 - r)),
                    e_i(12'(u * 4), {2'b01, 3'(r)}, 3'b010, {2'b01, 3'(7 - r)}, 7'h03), 1'b0, "R4 word load");
                chk(p_mw(3'b110, 7'(u * 4), 3'(r), 3'(7 - r)),
                    e_s(12'(u * 4), {2'b01, 3'(7 - r)}, {2'b01, 3'(r)}, 3'b010), 1'b0, "R4 word store");
                chk(p_md(3'b011, 8'(u * 8), 3'(r), 3'(7 - r)),
                    e_i(12'(u * 8), {2'b01, 3'(r)}, 3'b011, {2'b01, 3'(7 - r)}, 7'h03), 1'b0, "R4 dword load");
                chk(p_md(3'b111, 8'(u * 8), 3'(r), 3'(7 - r)),
                    e_s(12'(u * 8), {2'b01, 3'(7 - r)}, {2'b01, 3'(r)}, 3'b011), 1'b0, "R4 dword store");
            end

        // R5: stack-relative memory
        for (int rd = 0; rd < 32; rd += 5)
            for (int u = 0; u < 64; u++) begin
                chk_x(p_lwsp(5'(rd), 8'(u * 4)), e_i(12'(u * 4), 5'd2, 3'b010, 5'(rd), 7'h03), rd == 0, "R5 word load sp");
                chk_x(p_ldsp(5'(rd), 9'(u * 8)), e_i(12'(u * 8), 5'd2, 3'b011, 5'(rd), 7'h03), rd == 0, "R5 dword load sp");
                chk(p_swsp(5'(rd), 8'(u * 4)), e_s(12'(u * 4), 5'(rd), 5'd2, 3'b010), 1'b0, "R5 word store sp");
                chk(p_sdsp(5'(rd), 9'(u * 8)), e_s(12'(u * 8), 5'(rd), 5'd2, 3'b011), 1'b0, "R5 dword store sp");
            end

        // R6: add-immediate, 32-bit add-immediate, load immediate
        for (int rd = 0; rd < 32; rd++)
            for (int v = -32; v < 32; v++) begin
                chk_x(p_ci(3'b000, 6'(v), 5'(rd), 2'b01), e_i(12'(v), 5'(rd), 3'd0, 5'(rd), 7'h13),
                      (rd == 0) != (v == 0), "R6 add imm");
                chk_x(p_ci(3'b001, 6'(v), 5'(rd), 2'b01), e_i(12'(v), 5'(rd), 3'd0, 5'(rd), 7'h1b),
                      rd == 0, "R6 add imm word");
                chk_x(p_ci(3'b010, 6'(v), 5'(rd), 2'b01), e_i(12'(v), 5'd0, 3'd0, 5'(rd), 7'h13),
                      rd == 0, "R6 load imm");
            end

        // R7: stack adjust and upper immediate
        for (int v = -32; v < 32; v++)
            chk_x(p_a16(10'(v * 16)), e_i(12'(v * 16), 5'd2, 3'd0, 5'd2, 7'h13), v == 0, "R7 stack adjust");
        for (int rd = 0; rd < 32; rd++)
            for (int v = -32; v < 32; v++)
                if (rd != 2)
                    chk_x(p_ci(3'b011, 6'(v), 5'(rd), 2'b01), {20'(v), 5'(rd), 7'h37},
                          rd == 0 || v == 0, "R7 upper imm");

        // R8: shifts and and-immediate
        for (int r = 0; r < 8; r++)
            for (int s = 0; s < 64; s++) begin
                chk_x(p_cb(2'b00, 6'(s), 3'(r)), e_i({6'b000000, 6'(s)}, {2'b01, 3'(r)}, 3'b101, {2'b01, 3'(r)}, 7'h13),
                      s == 0, "R8 logical right");
                chk_x(p_cb(2'b01, 6'(s), 3'(r)), e_i({6'b010000, 6'(s)}, {2'b01, 3'(r)}, 3'b101, {2'b01, 3'(r)}, 7'h13),
                      s == 0, "R8 arith right");
                chk_x(p_ci(3'b000, 6'(s), 5'(r * 4 + 1), 2'b10), e_i({6'b0, 6'(s)}, 5'(r * 4 + 1), 3'b001, 5'(r * 4 + 1), 7'h13),
                      s == 0, "R8 left shift");
                chk(p_cb(2'b10, 6'(s), 3'(r)), e_i(12'(s - ((s >= 32) ? 64 : 0)), {2'b01, 3'(r)}, 3'b111, {2'b01, 3'(r)}, 7'h13),
                    1'b0, "R8 and imm");
            end

        // R9: register ALU group
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int sel = 0; sel < 8; sel++) begin
                    logic [31:0] ew;
                    logic [4:0]  ra;
                    logic [4:0]  rb;
                    ra = {2'b01, 3'(a)};
                    rb = {2'b01, 3'(b)};
                    case (sel)
                        0: ew = e_r(7'b0100000, rb, ra, 3'b000, ra, 7'h33);
                        1: ew = e_r(7'b0000000, rb, ra, 3'b100, ra, 7'h33);
                        2: ew = e_r(7'b0000000, rb, ra, 3'b110, ra, 7'h33);
                        3: ew = e_r(7'b0000000, rb, ra, 3'b111, ra, 7'h33);
                        4: ew = e_r(7'b0100000, rb, ra, 3'b000, ra, 7'h3b);
                        5: ew = e_r(7'b0000000, rb, ra, 3'b000, ra, 7'h3b);
                        default: ew = 32'h0;
                    endcase
                    chk_x(p_alu(3'(sel), 3'(a), 3'(b)), ew, sel >= 6, "R9 register alu");
                end

        // R10: jump offsets across the full signed range
        for (int o = -2048; o < 2048; o += 2)
            chk(p_j(12'(o)), e_j(21'(o)), 1'b0, "R10 jump");

        // R11: zero-compare branches
        for (int r = 0; r < 8; r++)
            for (int o = -256; o < 256; o += 2) begin
                chk(p_br(3'b110, 9'(o), 3'(r)), e_b(13'(o), {2'b01, 3'(r)}, 3'b000), 1'b0, "R11 branch zero");
                chk(p_br(3'b111, 9'(o), 3'(r)), e_b(13'(o), {2'b01, 3'(r)}, 3'b001), 1'b0, "R11 branch nonzero");
            end

        // R12: register jumps, move, add, breakpoint
        for (int rd = 0; rd < 32; rd++)
            for (int rs = 0; rs < 32; rs++) begin
                if (rs == 0) begin
                    chk_x(p_cr(1'b0, 5'(rd), 5'd0), e_i(12'd0, 5'(rd), 3'd0, 5'd0, 7'h67), rd == 0, "R12 reg jump");
                    chk(p_cr(1'b1, 5'(rd), 5'd0),
                        (rd == 0) ? 32'h00100073 : e_i(12'd0, 5'(rd), 3'd0, 5'd1, 7'h67), 1'b0, "R12 reg jump link");
                end else begin
                    chk_x(p_cr(1'b0, 5'(rd), 5'(rs)), e_r(7'd0, 5'(rs), 5'd0, 3'd0, 5'(rd), 7'h33), rd == 0, "R12 move");
                    chk(p_cr(1'b1, 5'(rd), 5'(rs)), e_r(7'd0, 5'(rs), 5'(rd), 3'd0, 5'(rd), 7'h33), 1'b0, "R12 add");
                end
            end

        // R1 R2 R13: every parcel, structural relations
        for (int k = 0; k < 65536; k++) begin
            logic [15:0] p;
            logic        need_bad;
            p = 16'(k);
            @(negedge clk);
            parcel = p;
            #1;
            n_vec++;
            need_bad = (p[1:0] == 2'b11)
                    || (p[1:0] == 2'b00 && (p[15:13] == 3'b001 || p[15:13] == 3'b100 || p[15:13] == 3'b101))
                    || (p[1:0] == 2'b10 && (p[15:13] == 3'b001 || p[15:13] == 3'b101));
            if (need_bad && !ill) begin
                n_bad++;
                $display("FAIL R13/R1 parcel=%h got ill=%b exp ill=1", p, ill);
            end else if (ill && word != 32'h0) begin
                n_bad++;
                $display("FAIL R2 parcel=%h got word=%h exp word=00000000", p, word);
            end else if (!ill && word[1:0] != 2'b11) begin
                n_bad++;
                $display("FAIL R2 parcel=%h got tail=%b exp tail=11", p, word[1:0]);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule